// File: doc/BRIEF.md
# Cascadable ALU Slice with Shared Adder Terms

This block is a purely combinational slice of an arithmetic and logic unit, four bits wide by default. One ripple-carry adder does the addition, and the same adder provides the logic results: the per-bit AND and XOR terms it computes for sum and carry are sent straight to the output selector. A per-bit OR term completes the set. A 3-bit operation code picks one of eight results. These are inversion of A, XOR, OR, addition, AND, a one-place left or right shift through the carry, and a forced zero. The result bus is one bit wider than the operands. Its top bit holds the adder carry-out or the bit shifted out of A.

The slice also produces three comparison flags: A is zero, A equals B, and the low result bits are zero. Each flag has a cascade input from a less significant slice and one shared cascade enable. When the enable is high, every incoming flag is ANDed into the local term. When it is low, the incoming flags are disregarded. Wide words are built by chaining slices. Each slice passes its carry-out and its flags to the next, and the least significant slice takes its carry and its cascade enable from outside. The forced-zero operation exists so that a slice can refresh the flags without producing a value.

Top module: `alu_slice`

## Requirements
- R1: `op_sel_i` codes 0, 1, 2 and 4 give bitwise NOT A, A XOR B, A OR B and A AND B in `result_o[3:0]`, with `result_o[4]` equal to 0.
- R2: Code 3 gives `result_o` = A + B + `carry_i` as a 5-bit sum, so bit 4 is the carry-out.
- R3: Code 5 gives `result_o[3:0]` = {A[2:0], `carry_i`} and `result_o[4]` = A[3].
- R4: Code 6 gives `result_o[3:0]` = {`carry_i`, A[3:1]} and `result_o[4]` = A[0].
- R5: Code 7 gives `result_o` = 0 whatever the values of A, B and `carry_i`.
- R6: `carry_o` always equals bit 4 of A + B + `carry_i`, whatever operation is selected.
- R7: `a_zero_o` is 1 exactly when A is 0 and the gated cascade input `az_casc_i` allows it.
- R8: `a_eq_b_o` is 1 exactly when A equals B and the gated cascade input `eq_casc_i` allows it.
- R9: The local part of `res_zero_o` is 1 exactly when `result_o[3:0]` is 0, for every operation, and it ignores `result_o[4]`.
- R10: When `casc_en_i` is 1, each flag output is its local term ANDed with its cascade input. When `casc_en_i` is 0, the cascade inputs have no effect and each flag equals its local term.
- R11: Two slices chained through the carry and the flags, with the low slice's cascade disabled and the high slice's enabled, give the 8-bit sum and the 8-bit zero and equality flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| carry_i | input | 1 | Carry into the adder and the shift fill bit |
| op_sel_i | input | 3 | Operation code |
| casc_en_i | input | 1 | Enables the three flag cascade inputs |
| az_casc_i | input | 1 | A-is-zero flag from the less significant slice |
| eq_casc_i | input | 1 | A-equals-B flag from the less significant slice |
| rz_casc_i | input | 1 | Result-is-zero flag from the less significant slice |
| result_o | output | 5 | Selected result; bit 4 holds the carry-out or shifted-out bit |
| carry_o | output | 1 | Adder carry-out toward the next slice |
| a_zero_o | output | 1 | A is zero, cascaded |
| a_eq_b_o | output | 1 | A equals B, cascaded |
| res_zero_o | output | 1 | Low result bits are zero, cascaded |

## Verification
The slice holds no state, so any internal fault appears at the ports as soon as the inputs change, with no delay. A broken AND or XOR term inside the adder produces a wrong sum and also a wrong logic result or a wrong equality flag for the same operands. A wrong carry link shows up only for operand pairs that carry into the faulty bit. For this reason the sweep covers every A, B, carry and operation code, and checks each pattern together with several cascade settings.

// File: rtl/alu_slice_pkg.sv
// Package: shared operation codes and per-bit term bundle for the ALU slice.
// Assumes: the encodings below are fixed by the instruction decoder upstream.
package alu_slice_pkg;

    typedef enum logic [2:0] {
        OP_INV_A = 3'd0,
        OP_XOR   = 3'd1,
        OP_OR    = 3'd2,
        OP_ADD   = 3'd3,
        OP_AND   = 3'd4,
        OP_SHL   = 3'd5,
        OP_SHR   = 3'd6,
        OP_ZERO  = 3'd7
    } alu_op_e;

    // Terms one adder bit produces; the logic results reuse them.
    typedef struct packed {
        logic and_t;
        logic xor_t;
        logic or_t;
        logic sum_t;
    } bit_terms_t;

endpackage

// File: rtl/alu_logic_cell.sv
// Module: one-bit full adder whose internal terms are exported as logic results.
// Assumes: purely combinational; carry ripples from the neighbour cell.
module alu_logic_cell
    import alu_slice_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       c_i,
    output bit_terms_t terms_o,
    output logic       c_o
);

    logic half_x;
    logic half_a;

    // Half-adder terms shared between the sum path and the logic outputs.
    always_comb begin
        half_x = a_i ^ b_i;
        half_a = a_i & b_i;
    end

    // Full-adder completion plus the extra OR term.
    always_comb begin
        terms_o.and_t = half_a;
        terms_o.xor_t = half_x;
        terms_o.or_t  = a_i | b_i;
        terms_o.sum_t = half_x ^ c_i;
        c_o           = half_a | (half_x & c_i);
    end

endmodule

// File: rtl/alu_ripple.sv
// Module: ripple chain of logic cells forming the slice adder.
// Assumes: WIDTH >= 2; carry enters at bit 0.
module alu_ripple
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_o
);

    logic       [WIDTH:0]   chain;
    bit_terms_t [WIDTH-1:0] terms;

    assign chain[0] = c_i;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        alu_logic_cell u_cell (
            .a_i     (a_i[gi]),
            .b_i     (b_i[gi]),
            .c_i     (chain[gi]),
            .terms_o (terms[gi]),
            .c_o     (chain[gi+1])
        );
        // Unpack one cell's terms into the bus vectors.
        always_comb begin
            and_o[gi] = terms[gi].and_t;
            xor_o[gi] = terms[gi].xor_t;
            or_o[gi]  = terms[gi].or_t;
            sum_o[gi] = terms[gi].sum_t;
        end
    end

    assign c_o = chain[WIDTH];

endmodule

// File: rtl/alu_result_mux.sv
// Module: eight-way result selector including shifts through carry.
// Assumes: top result bit is zero for the bitwise operations.
module alu_result_mux
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int RW = WIDTH + 1
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic             c_i,
    input  logic [WIDTH-1:0] and_i,
    input  logic [WIDTH-1:0] xor_i,
    input  logic [WIDTH-1:0] or_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             cout_i,
    output logic [RW-1:0]    res_o
);

    // Pick one candidate per operation code.
    always_comb begin
        unique case (op_i)
            OP_INV_A: res_o = {1'b0, ~a_i};
            OP_XOR:   res_o = {1'b0, xor_i};
            OP_OR:    res_o = {1'b0, or_i};
            OP_ADD:   res_o = {cout_i, sum_i};
            OP_AND:   res_o = {1'b0, and_i};
            OP_SHL:   res_o = {a_i, c_i};
            OP_SHR:   res_o = {a_i[0], c_i, a_i[WIDTH-1:1]};
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: comparison flags with gated cascade inputs.
// Assumes: a disabled cascade reads as "true" so the local term passes.
module alu_flag_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] xor_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             casc_en_i,
    input  logic             az_casc_i,
    input  logic             eq_casc_i,
    input  logic             rz_casc_i,
    output logic             a_zero_o,
    output logic             a_eq_b_o,
    output logic             res_zero_o
);

    logic az_loc, eq_loc, rz_loc;
    logic az_in, eq_in, rz_in;

    // Local terms: AND of inverted A, NOR of XOR terms, NOR of result bits.
    always_comb begin
        az_loc = &(~a_i);
        eq_loc = ~(|xor_i);
        rz_loc = ~(|res_i);
    end

    // Gate cascade inputs by the enable; disabled inputs are neutral.
    always_comb begin
        az_in = az_casc_i | ~casc_en_i;
        eq_in = eq_casc_i | ~casc_en_i;
        rz_in = rz_casc_i | ~casc_en_i;
    end

    // Combine local and incoming terms.
    always_comb begin
        a_zero_o   = az_loc & az_in;
        a_eq_b_o   = eq_loc & eq_in;
        res_zero_o = rz_loc & rz_in;
    end

endmodule

// File: rtl/alu_slice.sv
// Module: cascadable ALU slice (top). Combinational, no clock or reset.
// Assumes: carry_i and the cascade inputs come from the less significant
//          slice, or from outside on the lowest slice.
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int RW = WIDTH + 1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    input  logic [2:0]       op_sel_i,
    input  logic             casc_en_i,
    input  logic             az_casc_i,
    input  logic             eq_casc_i,
    input  logic             rz_casc_i,
    output logic [RW-1:0]    result_o,
    output logic             carry_o,
    output logic             a_zero_o,
    output logic             a_eq_b_o,
    output logic             res_zero_o
);

    logic [WIDTH-1:0] and_v, xor_v, or_v, sum_v;
    logic             add_c;
    alu_op_e          op;

    assign op = alu_op_e'(op_sel_i);

    alu_ripple #(.WIDTH(WIDTH)) u_ripple (
        .a_i   (a_i),
        .b_i   (b_i),
        .c_i   (carry_i),
        .and_o (and_v),
        .xor_o (xor_v),
        .or_o  (or_v),
        .sum_o (sum_v),
        .c_o   (add_c)
    );

    alu_result_mux #(.WIDTH(WIDTH)) u_mux (
        .op_i   (op),
        .a_i    (a_i),
        .c_i    (carry_i),
        .and_i  (and_v),
        .xor_i  (xor_v),
        .or_i   (or_v),
        .sum_i  (sum_v),
        .cout_i (add_c),
        .res_o  (result_o)
    );

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .a_i        (a_i),
        .xor_i      (xor_v),
        .res_i      (result_o[WIDTH-1:0]),
        .casc_en_i  (casc_en_i),
        .az_casc_i  (az_casc_i),
        .eq_casc_i  (eq_casc_i),
        .rz_casc_i  (rz_casc_i),
        .a_zero_o   (a_zero_o),
        .a_eq_b_o   (a_eq_b_o),
        .res_zero_o (res_zero_o)
    );

    assign carry_o = add_c;

endmodule

// File: rtl/alu_slice_checker.sv
// Module: port-level checker for alu_slice, attached by bind.
// Assumes: inputs settle before the checks are evaluated.
module alu_slice_checker #(
    parameter int WIDTH = 4,
    localparam int RW = WIDTH + 1
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             carry_i,
    input logic [2:0]       op_sel_i,
    input logic             casc_en_i,
    input logic             az_casc_i,
    input logic             eq_casc_i,
    input logic             rz_casc_i,
    input logic [RW-1:0]    result_o,
    input logic             carry_o,
    input logic             a_zero_o,
    input logic             a_eq_b_o,
    input logic             res_zero_o
);

    logic [RW-1:0] ref_sum;
    logic          gate_ok;

    // Arithmetic reference and cascade gate used by the checks.
    always_comb begin
        ref_sum = RW'(a_i) + RW'(b_i) + RW'(carry_i);
        gate_ok = ~casc_en_i;
    end

    // Port relations checked whenever inputs change.
    always_comb begin
        if (op_sel_i == 3'd3) AST_ADD_SUM: assert (result_o == ref_sum) else $error("add mismatch"); // R2
        if (op_sel_i == 3'd7) AST_FORCED_ZERO: assert (result_o == '0) else $error("zero op mismatch"); // R5
        if (op_sel_i inside {3'd0, 3'd1, 3'd2, 3'd4}) AST_LOGIC_TOP_CLEAR: assert (!result_o[WIDTH]) else $error("top bit set"); // R1
        AST_CARRY_OUT: assert (carry_o == ref_sum[WIDTH]) else $error("carry mismatch"); // R6
        if (gate_ok) AST_AZ_LOCAL: assert (a_zero_o == (a_i == '0)) else $error("a zero mismatch"); // R7
        if (gate_ok) AST_EQ_LOCAL: assert (a_eq_b_o == (a_i == b_i)) else $error("equal mismatch"); // R8
        if (gate_ok) AST_RZ_LOCAL: assert (res_zero_o == (result_o[WIDTH-1:0] == '0)) else $error("result zero mismatch"); // R9
        if (casc_en_i && !az_casc_i) AST_AZ_CASC_BLOCK: assert (!a_zero_o) else $error("cascade ignored"); // R10
        if (casc_en_i && !eq_casc_i) AST_EQ_CASC_BLOCK: assert (!a_eq_b_o) else $error("cascade ignored"); // R10
        if (casc_en_i && !rz_casc_i) AST_RZ_CASC_BLOCK: assert (!res_zero_o) else $error("cascade ignored"); // R10
    end

endmodule

bind alu_slice alu_slice_checker #(.WIDTH(WIDTH)) u_alu_slice_checker (
    .a_i        (a_i),
    .b_i        (b_i),
    .carry_i    (carry_i),
    .op_sel_i   (op_sel_i),
    .casc_en_i  (casc_en_i),
    .az_casc_i  (az_casc_i),
    .eq_casc_i  (eq_casc_i),
    .rz_casc_i  (rz_casc_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .a_zero_o   (a_zero_o),
    .a_eq_b_o   (a_eq_b_o),
    .res_zero_o (res_zero_o)
);

// File: tb/alu_slice_bench.sv
// Bench: exhaustive sweep of one slice plus a two-slice chain.
module alu_slice_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Single slice under test.
    logic [3:0] a, b;
    logic       cin, cen, azc, eqc, rzc;
    logic [2:0] op;
    logic [4:0] res;
    logic       cout, az, eq, rz;

    alu_slice u_alu_slice (
        .a_i(a), .b_i(b), .carry_i(cin), .op_sel_i(op),
        .casc_en_i(cen), .az_casc_i(azc), .eq_casc_i(eqc), .rz_casc_i(rzc),
        .result_o(res), .carry_o(cout), .a_zero_o(az), .a_eq_b_o(eq), .res_zero_o(rz)
    );

    // Two-slice chain: low slice cascade off, high slice cascade on.
    logic [7:0] ca, cb;
    logic       ccin;
    logic [4:0] lo_res, hi_res;
    logic       lo_c, hi_c, lo_az, lo_eq, lo_rz, hi_az, hi_eq, hi_rz;

    alu_slice u_lo (
        .a_i(ca[3:0]), .b_i(cb[3:0]), .carry_i(ccin), .op_sel_i(3'd3),
        .casc_en_i(1'b0), .az_casc_i(1'b0), .eq_casc_i(1'b0), .rz_casc_i(1'b0),
        .result_o(lo_res), .carry_o(lo_c), .a_zero_o(lo_az), .a_eq_b_o(lo_eq), .res_zero_o(lo_rz)
    );
    alu_slice u_hi (
        .a_i(ca[7:4]), .b_i(cb[7:4]), .carry_i(lo_c), .op_sel_i(3'd3),
        .casc_en_i(1'b1), .az_casc_i(lo_az), .eq_casc_i(lo_eq), .rz_casc_i(lo_rz),
        .result_o(hi_res), .carry_o(hi_c), .a_zero_o(hi_az), .a_eq_b_o(hi_eq), .res_zero_o(hi_rz)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h (a=%0h b=%0h cin=%0b op=%0d cen=%0b)",
                     req, got, exp, a, b, cin, op, cen);
        end
    endtask

    // Watchdog: counts cycles after reset and ends a hung run.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else cyc <= cyc + 1;
    end

    initial begin
        wait (cyc > 150000 || done);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 0; op = 3'd7; cen = 0; azc = 0; eqc = 0; rzc = 0;
        ca = '0; cb = '0; ccin = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset-state style check: forced zero with A=B=0, cascade off.
        chk("R5 idle result", int'(res), 0);
        chk("R9 idle rz", int'(rz), 1);

        for (int opi = 0; opi < 8; opi++) begin
            for (int ai = 0; ai < 16; ai++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        for (int ki = 0; ki < 4; ki++) begin
                            logic [4:0] sum5, exp_res;
                            logic [3:0] av, bv;
                            logic       gz, ge, gr;
                            av = 4'(ai); bv = 4'(bi);
                            a = av; b = bv; cin = ci[0]; op = 3'(opi);
                            cen = ki[1];
                            azc = ki[0]; eqc = ~ki[0]; rzc = ki[0] ^ av[0];
                            #1;
                            sum5 = 5'(av) + 5'(bv) + 5'(ci);
                            case (opi)
                                0: exp_res = {1'b0, ~av};
                                1: exp_res = {1'b0, av ^ bv};
                                2: exp_res = {1'b0, av | bv};
                                3: exp_res = sum5;
                                4: exp_res = {1'b0, av & bv};
                                5: exp_res = {av, ci[0]};
                                6: exp_res = {av[0], ci[0], av[3:1]};
                                default: exp_res = 5'd0;
                            endcase
                            gz = cen ? azc : 1'b1;
                            ge = cen ? eqc : 1'b1;
                            gr = cen ? rzc : 1'b1;
                            if (opi inside {0, 1, 2, 4}) chk("R1 logic", int'(res), int'(exp_res));
                            else if (opi == 3) chk("R2 add", int'(res), int'(exp_res));
                            else if (opi == 5) chk("R3 shl", int'(res), int'(exp_res));
                            else if (opi == 6) chk("R4 shr", int'(res), int'(exp_res));
                            else chk("R5 zero", int'(res), int'(exp_res));
                            chk("R6 carry", int'(cout), int'(sum5[4]));
                            if (cen) begin
                                chk("R10 az cascade", int'(az), int'((av == 0) && gz));
                                chk("R10 eq cascade", int'(eq), int'((av == bv) && ge));
                                chk("R10 rz cascade", int'(rz), int'((exp_res[3:0] == 0) && gr));
                            end else begin
                                chk("R7 a zero", int'(az), int'(av == 0));
                                chk("R8 a eq b", int'(eq), int'(av == bv));
                                chk("R9 res zero", int'(rz), int'(exp_res[3:0] == 0));
                            end
                        end
                    end
                end
            end
        end

        // R9 boundary: carry-out set but low bits zero keeps flag high.
        a = 4'hF; b = 4'h1; cin = 0; op = 3'd3; cen = 0; #1;
        chk("R9 carry ignored", int'(rz), 1);
        // R10 boundary: cascade off, cascade inputs toggled, flags unchanged.
        a = 4'h0; b = 4'h0; op = 3'd7; cen = 0; azc = 0; eqc = 0; rzc = 0; #1;
        chk("R10 ignored az", int'(az), 1);
        chk("R10 ignored eq", int'(eq), 1);
        chk("R10 ignored rz", int'(rz), 1);

        // R11: chained 8-bit add sweep.
        for (int xi = 0; xi < 256; xi += 3) begin
            for (int yi = 0; yi < 256; yi++) begin
                logic [8:0] s9;
                ca = 8'(xi); cb = 8'(yi); ccin = yi[0] ^ xi[0];
                #1;
                s9 = 9'(ca) + 9'(cb) + 9'(ccin);
                chk("R11 chain sum", int'({hi_c, hi_res[3:0], lo_res[3:0]}), int'(s9));
                chk("R11 chain az", int'(hi_az), int'(ca == 0));
                chk("R11 chain eq", int'(hi_eq), int'(ca == cb));
                chk("R11 chain rz", int'(hi_rz), int'(s9[7:0] == 0));
            end
        end
        ca = 8'h00; cb = 8'h00; ccin = 0; #1;
        chk("R11 chain all zero", int'({hi_az, hi_eq, hi_rz}), 7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule